// File: doc/BRIEF.md
# H-Bridge Charge/Flyback Gate Sequencer

This block converts a pulse-width-modulated drive signal and a half-cycle polarity bit into the four gate commands of a full H-bridge feeding an inductor-filtered load. It does not switch the two legs in plain complementary fashion. One leg is the active leg for the current half-cycle. Its high-side switch follows the PWM on-time, which is the charge interval. When the on-time ends, the same leg's low-side switch closes, which is the flyback interval. The other leg keeps its low-side switch closed for the whole half-cycle. During flyback the inductor current therefore circulates through both low-side switches.

When the polarity bit flips, the two legs trade roles and the same pattern is mirrored. The new polarity is taken only at a rising PWM edge. Before the new mapping applies, all four gates are held off for one dead-time interval. A programmable dead time separates any turn-off from the turn-on of the other switch on the same leg. Deasserting enable or applying reset drives every gate low. All inputs are assumed synchronous to the clock. The duty values, the gate drivers and current sensing are outside this block.

Top module: `hbridge_gate_seq`

## Requirements
- R1: With polarity 0 (leg A active) and PWM high, the gates settle to leg A high-side on, leg B low-side on, and the other two off.
- R2: With polarity 0 and PWM low, the gates settle to both low-side switches on and both high-side switches off.
- R3: While enabled and with no polarity change accepted, the low-side switch of the inactive leg (leg B for polarity 0) stays on in every cycle, including the dead-time gaps between charge and flyback.
- R4: With polarity 1 (leg B active) the pattern is mirrored: leg B high-side and leg A low-side during charge, both low sides during flyback, and leg A low-side held on through the dead-time gap.
- R5: When the active high-side switch turns off, the same-leg low-side switch turns on after exactly DEAD_CYCLES clock cycles in which both switches of that leg are off.
- R6: When the active low-side switch turns off for a new on-time, the same-leg high-side switch turns on after exactly DEAD_CYCLES cycles with both switches of that leg off.
- R7: A change of the polarity input has no effect on the gates unless a PWM rising edge occurs while the requested polarity differs from the one in use.
- R8: An accepted polarity change turns all four gates off for exactly DEAD_CYCLES cycles. After that the mirrored mapping for the new polarity applies.
- R9: Reset, or enable low, forces all four gates low no later than the second clock edge after it is sampled. After enable rises, all gates remain off for a further DEAD_CYCLES cycles before a mapping applies.
- R10: The high-side and low-side gates of one leg are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; low forces all gates off |
| pwm | input | 1 | Duty signal; high is the charge interval |
| polarity | input | 1 | Half-cycle select: 0 makes leg A active, 1 makes leg B active |
| gate_ah | output | 1 | Leg A high-side gate |
| gate_al | output | 1 | Leg A low-side gate |
| gate_bh | output | 1 | Leg B high-side gate |
| gate_bl | output | 1 | Leg B low-side gate |

## Verification
The bench builds the block with DEAD_CYCLES set to 3, instead of the default 8. PWM phases of about ten cycles then cover full charge, gap and flyback sequences. With a short dead time, the exact length of every gap can be counted sample by sample, and each length must equal 3. Polarity changes are applied at a PWM rising edge, while PWM is held high, and while PWM is held low. This separates accepted swaps from ignored requests.

// File: rtl/hbg_pkg.sv
// Package: shared types of the H-bridge gate sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package hbg_pkg;

    // Sequencer phases. The dead-time phases hold one leg or every leg open.
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_CHARGE  = 3'd1,
        ST_FLY     = 3'd2,
        ST_DT_CHG  = 3'd3,
        ST_DT_FLY  = 3'd4,
        ST_DT_SWAP = 3'd5
    } seq_state_t;

endpackage

// File: rtl/hbg_swap_latch.sv
// Module: hbg_swap_latch
// Detects the PWM rising edge. At that edge it decides whether a polarity
// change is requested, and it holds the request until the sequencer
// acknowledges it. A request raised during a dead-time phase is kept, so it
// is not lost.
// Assumes: pwm and polarity are synchronous to clk.
module hbg_swap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pwm,
    input  logic polarity,
    input  logic act_pol,
    input  logic ack,
    output logic swap_req,
    output logic swap_pol
);

    logic pwm_q;
    logic pend_q;
    logic pol_q;
    logic rise;
    logic differs;

    // Rising edge of the duty signal and a mismatch of the requested polarity.
    always_comb begin
        rise     = pwm & ~pwm_q;
        differs  = polarity ^ act_pol;
        swap_req = enable & (pend_q | (rise & differs));
        swap_pol = pend_q ? pol_q : polarity;
    end

    // Previous PWM level and the pending swap request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q  <= 1'b0;
            pend_q <= 1'b0;
            pol_q  <= 1'b0;
        end else begin
            pwm_q <= pwm;
            if (!enable || ack) begin
                pend_q <= 1'b0;
            end else if (rise && differs) begin
                pend_q <= 1'b1;
                pol_q  <= polarity;
            end
        end
    end

    // R7: a pending swap only ever appears right after a PWM rising edge.
    assert_pend_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> ($past(pwm) && !$past(pwm_q)));

endmodule

// File: rtl/hbg_seq_fsm.sv
// Module: hbg_seq_fsm
// Phase sequencer. It steps between charge and flyback, with a dead-time
// phase between them. It runs a longer all-off phase when the bridge starts
// up or when the legs swap roles, and it owns the polarity in use.
// Assumes: DEAD_CYCLES >= 1; swap_req and swap_pol come from hbg_swap_latch.
module hbg_seq_fsm
    import hbg_pkg::*;
#(
    parameter int DEAD_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       pwm,
    input  logic       swap_req,
    input  logic       swap_pol,
    output seq_state_t state,
    output logic       act_pol,
    output logic       ack
);

    localparam int CNT_W = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEAD_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             nxt_pol;
    logic             last;

    // End of the current dead-time interval and the swap acknowledge.
    always_comb begin
        last = (cnt == CNT_LAST);
        ack  = enable && ((state == ST_OFF) ||
               (((state == ST_CHARGE) || (state == ST_FLY)) && swap_req));
    end

    // Phase, dead-time counter and polarity registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            cnt     <= '0;
            act_pol <= 1'b0;
            nxt_pol <= 1'b0;
        end else if (!enable) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            case (state)
                ST_OFF: begin
                    state   <= ST_DT_SWAP;
                    cnt     <= '0;
                    nxt_pol <= swap_pol;
                end
                ST_CHARGE: begin
                    if (swap_req) begin
                        state   <= ST_DT_SWAP;
                        cnt     <= '0;
                        nxt_pol <= swap_pol;
                    end else if (!pwm) begin
                        state <= ST_DT_FLY;
                        cnt   <= '0;
                    end
                end
                ST_FLY: begin
                    if (swap_req) begin
                        state   <= ST_DT_SWAP;
                        cnt     <= '0;
                        nxt_pol <= swap_pol;
                    end else if (pwm) begin
                        state <= ST_DT_CHG;
                        cnt   <= '0;
                    end
                end
                ST_DT_CHG: begin
                    if (last) state <= ST_CHARGE;
                    else      cnt   <= cnt + CNT_ONE;
                end
                ST_DT_FLY: begin
                    if (last) state <= ST_FLY;
                    else      cnt   <= cnt + CNT_ONE;
                end
                ST_DT_SWAP: begin
                    if (last) begin
                        act_pol <= nxt_pol;
                        state   <= pwm ? ST_CHARGE : ST_FLY;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                default: begin
                    state <= ST_OFF;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R8: the polarity in use changes only when an all-off phase completes.
    assert_pol_change_after_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pol != $past(act_pol)) |-> ($past(state) == ST_DT_SWAP));

    // R5: the dead-time counter never runs past its last value.
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

endmodule

// File: rtl/hbg_leg_drive.sv
// Module: hbg_leg_drive
// Gate decode for one bridge leg. It maps the sequencer phase, and whether
// this leg is the active leg, onto registered high-side and low-side
// commands. The outputs are registered so that a multi-bit phase change
// cannot glitch a gate.
// Assumes: LEG_ID is 0 for leg A and 1 for leg B; DEAD_CYCLES matches the
// sequencer.
module hbg_leg_drive
    import hbg_pkg::*;
#(
    parameter int LEG_ID      = 0,
    parameter int DEAD_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state,
    input  logic       act_pol,
    output logic       gate_h,
    output logic       gate_l
);

    localparam logic    MY_POL  = (LEG_ID != 0);
    localparam int      GUARD_W = $clog2(DEAD_CYCLES + 1);
    localparam logic [GUARD_W-1:0] GUARD_SAT = GUARD_W'(DEAD_CYCLES);
    localparam logic [GUARD_W-1:0] GUARD_ONE = GUARD_W'(1);

    logic active;
    logic want_h;
    logic want_l;

    // Role of this leg and the switch commands for the current phase.
    always_comb begin
        active = (act_pol == MY_POL);
        want_h = active && (state == ST_CHARGE);
        if (active) begin
            want_l = (state == ST_FLY);
        end else begin
            want_l = (state == ST_CHARGE) || (state == ST_FLY) ||
                     (state == ST_DT_CHG) || (state == ST_DT_FLY);
        end
    end

    // Registered gate outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_h <= 1'b0;
            gate_l <= 1'b0;
        end else begin
            gate_h <= want_h;
            gate_l <= want_l;
        end
    end

    // Checker state: cycles since each switch was last on, saturating.
    logic [GUARD_W-1:0] h_off_cnt;
    logic [GUARD_W-1:0] l_off_cnt;

    // Off-time counters that back the dead-time assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_off_cnt <= GUARD_SAT;
            l_off_cnt <= GUARD_SAT;
        end else begin
            h_off_cnt <= gate_h ? '0 : ((h_off_cnt == GUARD_SAT) ? GUARD_SAT : h_off_cnt + GUARD_ONE);
            l_off_cnt <= gate_l ? '0 : ((l_off_cnt == GUARD_SAT) ? GUARD_SAT : l_off_cnt + GUARD_ONE);
        end
    end

    // R10: the two switches of this leg never conduct together.
    assert_leg_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_h && gate_l));

    // R5: the low side closes only after the high side has been open DEAD_CYCLES cycles.
    assert_dead_h_to_l_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_l) |-> (h_off_cnt >= GUARD_SAT));

    // R6: the high side closes only after the low side has been open DEAD_CYCLES cycles.
    assert_dead_l_to_h_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_h) |-> (l_off_cnt >= GUARD_SAT));

endmodule

// File: rtl/hbridge_gate_seq.sv
// Module: hbridge_gate_seq (top)
// Charge/flyback gate sequencer for a full H-bridge. It ties together the
// swap latch, the phase sequencer and one decode instance per leg.
// Assumes: inputs are synchronous to clk; DEAD_CYCLES >= 1.
module hbridge_gate_seq
    import hbg_pkg::*;
#(
    parameter int DEAD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pwm,
    input  logic polarity,
    output logic gate_ah,
    output logic gate_al,
    output logic gate_bh,
    output logic gate_bl
);

    localparam int LEGS = 2;

    seq_state_t       state;
    logic             act_pol;
    logic             ack;
    logic             swap_req;
    logic             swap_pol;
    logic [LEGS-1:0]  gh;
    logic [LEGS-1:0]  gl;

    hbg_swap_latch u_swap (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .pwm      (pwm),
        .polarity (polarity),
        .act_pol  (act_pol),
        .ack      (ack),
        .swap_req (swap_req),
        .swap_pol (swap_pol)
    );

    hbg_seq_fsm #(
        .DEAD_CYCLES (DEAD_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .pwm      (pwm),
        .swap_req (swap_req),
        .swap_pol (swap_pol),
        .state    (state),
        .act_pol  (act_pol),
        .ack      (ack)
    );

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        hbg_leg_drive #(
            .LEG_ID      (g),
            .DEAD_CYCLES (DEAD_CYCLES)
        ) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .state   (state),
            .act_pol (act_pol),
            .gate_h  (gh[g]),
            .gate_l  (gl[g])
        );
    end

    // Leg A is index 0, leg B is index 1.
    assign gate_ah = gh[0];
    assign gate_al = gl[0];
    assign gate_bh = gh[1];
    assign gate_bl = gl[1];

    // R9: enable sampled low leaves every gate low two edges later.
    assert_disable_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> ##2 ({gate_ah, gate_al, gate_bh, gate_bl} == 4'b0000));

    // R8: the two high-side switches are never both on.
    assert_single_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_ah && gate_bh));

endmodule

// File: tb/hbridge_gate_seq_bench.sv
// Bench for hbridge_gate_seq: a vector table walked by one loop, then
// directed tests for dead-time lengths, swaps, reset and disable timing.
module hbridge_gate_seq_bench;

    localparam int DEAD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic pwm = 1'b0;
    logic polarity = 1'b0;
    logic gate_ah, gate_al, gate_bh, gate_bl;
    logic [3:0] gates;

    int checks = 0;
    int errors = 0;

    assign gates = {gate_ah, gate_al, gate_bh, gate_bl};

    always #5 clk = ~clk;

    hbridge_gate_seq #(.DEAD_CYCLES(DEAD)) u_hbridge_gate_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .pwm      (pwm),
        .polarity (polarity),
        .gate_ah  (gate_ah),
        .gate_al  (gate_al),
        .gate_bh  (gate_bh),
        .gate_bl  (gate_bl)
    );

    // Row layout: [6]=enable, [5]=pwm, [4]=polarity, [3:0]={ah,al,bh,bl} expected.
    localparam logic [6:0] VECS [0:11] = '{
        7'b0_0_0_0000,  // disabled
        7'b1_0_0_0101,  // R2 flyback, leg A active
        7'b1_1_0_1001,  // R1 charge, leg A active
        7'b1_0_0_0101,  // R2 back to flyback
        7'b1_0_1_0101,  // R7 polarity moved, no edge
        7'b1_1_1_0110,  // R4 swap at edge, charge leg B
        7'b1_0_1_0101,  // R4 flyback leg B
        7'b1_1_0_1001,  // R8 swap back at edge
        7'b1_1_1_1001,  // R7 polarity moved while pwm high
        7'b0_1_1_0000,  // R9 disable
        7'b1_1_1_0110,  // R9 re-enable picks current polarity
        7'b0_0_0_0000   // R9 disable
    };

    function automatic string row_tag(input int i);
        case (i)
            1, 3:    return "R2";
            2:       return "R1";
            4, 8:    return "R7";
            5, 6:    return "R4";
            7:       return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_vec(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s gates actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s gap actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Call right after driving inputs at a negedge: skip one sample, count the gap, check the end pattern.
    task automatic measure_gap(input string tag, input logic [3:0] gap_pat, input logic [3:0] fin);
        int n;
        n = 0;
        @(negedge clk);
        @(negedge clk);
        while (gates == gap_pat && n < 40) begin
            n++;
            @(negedge clk);
        end
        check_int(tag, n, DEAD);
        check_vec(tag, gates, fin);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int low_bl;
        // R9: reset holds all gates low even with enable and pwm high.
        enable = 1'b1;
        pwm = 1'b1;
        repeat (4) @(negedge clk);
        check_vec("R9 reset", gates, 4'b0000);
        enable = 1'b0;
        pwm = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table.
        for (int i = 0; i < 12; i++) begin
            enable   = VECS[i][6];
            pwm      = VECS[i][5];
            polarity = VECS[i][4];
            repeat (20) @(negedge clk);
            check_vec(row_tag(i), gates, VECS[i][3:0]);
        end

        // R9: start-up all-off gap, then flyback for leg A.
        enable = 1'b1; pwm = 1'b0; polarity = 1'b0;
        measure_gap("R9 startup", 4'b0000, 4'b0101);
        repeat (5) @(negedge clk);
        // R6: low side off, then high side on after DEAD cycles; leg B low held.
        pwm = 1'b1;
        measure_gap("R6 low-to-high", 4'b0001, 4'b1001);
        repeat (5) @(negedge clk);
        // R5: high side off, then low side on after DEAD cycles.
        pwm = 1'b0;
        measure_gap("R5 high-to-low", 4'b0001, 4'b0101);
        repeat (5) @(negedge clk);
        // R8: accepted swap with an all-off gap.
        polarity = 1'b1;
        repeat (5) @(negedge clk);
        check_vec("R7 no edge", gates, 4'b0101);
        pwm = 1'b1;
        measure_gap("R8 swap gap", 4'b0000, 4'b0110);
        repeat (5) @(negedge clk);
        // R4: mirrored gap keeps leg A low side on.
        pwm = 1'b0;
        measure_gap("R4 mirrored gap", 4'b0100, 4'b0101);
        repeat (5) @(negedge clk);
        // R7: request raised and withdrawn before any edge has no effect.
        polarity = 1'b0;
        repeat (3) @(negedge clk);
        polarity = 1'b1;
        @(negedge clk);
        pwm = 1'b1;
        measure_gap("R7 withdrawn request", 4'b0100, 4'b0110);
        pwm = 1'b0;
        repeat (10) @(negedge clk);
        // Back to leg A active through a swap.
        polarity = 1'b0;
        pwm = 1'b1;
        repeat (10) @(negedge clk);
        check_vec("R1 after swap", gates, 4'b1001);

        // R3: leg B low side stays on through charge and flyback cycles.
        low_bl = 0;
        for (int k = 0; k < 60; k++) begin
            pwm = ((k / 10) % 2) == 0;
            @(negedge clk);
            if (!gate_bl) low_bl++;
        end
        check_int("R3 opposite low held", low_bl, 0);

        // R9: disable clears the gates by the second edge.
        pwm = 1'b1;
        repeat (10) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_vec("R9 disable timing", gates, 4'b0000);

        // R9: synchronous reset during run.
        enable = 1'b1;
        repeat (12) @(negedge clk);
        check_vec("R1 re-run", gates, 4'b1001);
        rst_n = 1'b0;
        @(negedge clk);
        check_vec("R9 reset in run", gates, 4'b0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end

endmodule